// File: doc/BRIEF.md
# Serial Packet Receive Deserializer

This block sits between a bit-aligned, already sampled USB line and a link-layer packet engine. A one-cycle `bit_en` strobe marks each bit period in which the `line_dp`/`line_dm` pair carries a new symbol. The block finds the start of a packet in the synchronisation pattern and undoes the NRZI line coding. It then drops stuffed bits and gathers the payload into bytes. Each byte is handed over on a byte-wide bus alongside three indications: packet in progress, byte present, and error.

The end of a packet is recognised by a single-ended zero on the line. A leftover partial byte at that point counts as an error, as does a stuffing violation or a single-ended one inside the packet. In both of those cases the rest of the packet is discarded until the line next shows a single-ended zero. A raw mode, selected through `opmode`, takes payload bits straight from the line level without decoding or unstuffing. A separate two-bit line-state code is registered normally and passed through without a register while `suspend` is high.

Top module: `usb_rx_deser`

## Requirements
- R1: While reset is held, `rx_active`, `rx_valid`, `rx_error` are 0 and `line_state` is 00 (with `suspend` low).
- R2: J is dp=1/dm=0 and K is dp=0/dm=1. A decoded bit is 1 when the symbol equals the previous one and 0 on a change; the previous symbol is taken as J after any single-ended bit and after reset. Outside a packet, a decoded 1 that follows at least two consecutive decoded 0s marks the start of a packet: `rx_active` rises at the clock edge that samples that bit and stays high until the packet ends.
- R3: Payload bits after the start point are packed least significant bit first. `rx_valid` is high for exactly one cycle, in the cycle after the eighth payload bit is sampled, and `rx_data` holds the byte in that cycle. Synchronisation bits never appear on `rx_data`.
- R4: The run of decoded ones counts the final synchronisation bit. After six consecutive decoded ones, a following decoded 0 is discarded and the run count restarts.
- R5: A decoded 1 in a slot where a stuffed 0 is due is a violation. `rx_error` is high for one cycle, `rx_active` falls at the same edge, and no further byte is produced until the line has shown a single-ended zero.
- R6: A single-ended zero bit (dp=0, dm=0) during a packet ends it, and `rx_active` falls at the next edge. `rx_error` pulses at that same edge only when one to seven payload bits are pending.
- R7: A single-ended one bit (dp=1, dm=1) during a packet ends it in the same way as R5.
- R8: With `opmode` = 10, payload bits equal the `line_dp` level and no unstuffing or violation check takes place. Start detection still uses NRZI decoding.
- R9: With `suspend` low, `line_state` equals {`line_dm`, `line_dp`} as sampled at the previous clock edge. The codes are 00 SE0, 01 J, 10 K and 11 SE1.
- R10: With `suspend` high, `line_state` equals {`line_dm`, `line_dp`} in the same cycle.
- R11: When a violation lands on the bit that would complete a byte, the error wins: `rx_error` pulses and no `rx_valid` is produced for that byte.
- R12: The line is sampled only in cycles with `bit_en` high. Cycles with `bit_en` low change no packet state, whatever the line carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Marks a cycle carrying a new line symbol |
| line_dp | input | 1 | Sampled positive data line |
| line_dm | input | 1 | Sampled negative data line |
| suspend | input | 1 | Selects pass-through line-state reporting |
| opmode | input | 2 | 10 selects raw payload mode, other codes normal decoding |
| rx_data | output | DATA_W | Received payload byte |
| rx_active | output | 1 | Packet in progress |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_error | output | 1 | One-cycle receive error strobe |
| line_state | output | 2 | Line code {dm, dp} |

## Verification
Two things can fall on the same sampled bit: completion of a byte and detection of a stuffing violation. The bench provokes this by sending a zero followed by seven unstuffed ones, placed so that the seventh one is the eighth bit of a byte. It then requires exactly one error pulse and no byte strobe for the broken byte, with the earlier byte of the packet still delivered. Every cycle is also compared against a behavioural model, so the falling edge of `rx_active` and the error pulse must land together on that edge.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

    typedef enum logic [1:0] {
        RX_HUNT  = 2'd0,
        RX_BUSY  = 2'd1,
        RX_DRAIN = 2'd2
    } rx_phase_e;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_code_e;

    localparam logic [1:0] OPM_RAW = 2'b10;

endpackage

// File: rtl/usb_rx_nrzi.sv
module usb_rx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic line_dp,
    input  logic line_dm,
    output logic nrz_bit,
    output logic raw_bit,
    output logic is_se0,
    output logic is_se1
);
    logic prev_d, prev_q;

    always_comb begin
        is_se0  = !line_dp && !line_dm;
        is_se1  = line_dp && line_dm;
        nrz_bit = (line_dp == prev_q);
        raw_bit = line_dp;
        prev_d  = prev_q;
        if (bit_en) begin
            // single-ended symbols leave the reference at idle (J)
            prev_d = (is_se0 || is_se1) ? 1'b1 : line_dp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/usb_rx_sync_det.sv
module usb_rx_sync_det #(
    parameter int SYNC_ZEROS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hunt,
    input  logic bit_stb,
    input  logic nrz_bit,
    input  logic line_bad,
    output logic sop
);
    localparam int ZW = $clog2(SYNC_ZEROS + 1);

    logic [ZW-1:0] zeros_d, zeros_q;

    always_comb begin
        sop     = 1'b0;
        zeros_d = zeros_q;
        if (!hunt) begin
            zeros_d = '0;
        end else if (bit_stb) begin
            if (line_bad) begin
                zeros_d = '0;
            end else if (!nrz_bit) begin
                if (zeros_q != ZW'(SYNC_ZEROS)) zeros_d = zeros_q + ZW'(1);
            end else begin
                sop     = (zeros_q == ZW'(SYNC_ZEROS));
                zeros_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zeros_q <= '0;
        else        zeros_q <= zeros_d;
    end

endmodule

// File: rtl/usb_rx_packer.sv
module usb_rx_packer
    import usb_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int STUFF_LIMIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_mode,
    input  logic              bit_stb,
    input  logic              nrz_bit,
    input  logic              raw_bit,
    input  logic              is_se0,
    input  logic              is_se1,
    input  logic              sop,
    output logic              hunt,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_active,
    output logic              rx_error
);
    localparam int BCNT_W = $clog2(DATA_W);
    localparam int ONES_W = $clog2(STUFF_LIMIT + 1);

    typedef struct packed {
        rx_phase_e         phase;
        logic [DATA_W-1:0] shift;
        logic [BCNT_W-1:0] bcnt;
        logic [ONES_W-1:0] ones;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              active;
        logic              error;
    } pk_state_t;

    pk_state_t q, d;
    logic      b;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.error = 1'b0;
        b       = raw_mode ? raw_bit : nrz_bit;
        unique case (q.phase)
            RX_HUNT: begin
                if (sop) begin
                    d.phase  = RX_BUSY;
                    d.active = 1'b1;
                    d.ones   = ONES_W'(1);
                    d.bcnt   = '0;
                end
            end
            RX_BUSY: begin
                if (bit_stb) begin
                    if (is_se0) begin
                        d.phase  = RX_HUNT;
                        d.active = 1'b0;
                        d.error  = (q.bcnt != '0);
                    end else if (is_se1) begin
                        d.phase  = RX_DRAIN;
                        d.active = 1'b0;
                        d.error  = 1'b1;
                    end else if (!raw_mode && q.ones == ONES_W'(STUFF_LIMIT)) begin
                        if (b) begin
                            d.phase  = RX_DRAIN;
                            d.active = 1'b0;
                            d.error  = 1'b1;
                        end else begin
                            d.ones = '0;
                        end
                    end else begin
                        d.shift = {b, q.shift[DATA_W-1:1]};
                        d.ones  = (b && !raw_mode) ? q.ones + ONES_W'(1) : '0;
                        if (q.bcnt == BCNT_W'(DATA_W - 1)) begin
                            d.data  = {b, q.shift[DATA_W-1:1]};
                            d.valid = 1'b1;
                            d.bcnt  = '0;
                        end else begin
                            d.bcnt = q.bcnt + BCNT_W'(1);
                        end
                    end
                end
            end
            default: begin
                if (bit_stb && is_se0) d.phase = RX_HUNT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= RX_HUNT;
        end else begin
            q <= d;
        end
    end

    assign hunt      = (q.phase == RX_HUNT);
    assign rx_data   = q.data;
    assign rx_valid  = q.valid;
    assign rx_active = q.active;
    assign rx_error  = q.error;

endmodule

// File: rtl/usb_rx_linestate.sv
module usb_rx_linestate
    import usb_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       suspend,
    input  logic       line_dp,
    input  logic       line_dm,
    output logic [1:0] line_state
);
    logic [1:0] ls_d, ls_q;

    always_comb begin
        ls_d       = {line_dm, line_dp};
        line_state = suspend ? ls_d : ls_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ls_q <= LS_SE0;
        else        ls_q <= ls_d;
    end

endmodule

// File: rtl/usb_rx_deser.sv
module usb_rx_deser
    import usb_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int STUFF_LIMIT = 6,
    parameter int SYNC_ZEROS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              line_dp,
    input  logic              line_dm,
    input  logic              suspend,
    input  logic [1:0]        opmode,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_active,
    output logic              rx_valid,
    output logic              rx_error,
    output logic [1:0]        line_state
);
    logic nrz_bit, raw_bit, is_se0, is_se1;
    logic hunt, sop, raw_mode;

    assign raw_mode = (opmode == OPM_RAW);

    usb_rx_nrzi u_nrzi (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .line_dp (line_dp),
        .line_dm (line_dm),
        .nrz_bit (nrz_bit),
        .raw_bit (raw_bit),
        .is_se0  (is_se0),
        .is_se1  (is_se1)
    );

    usb_rx_sync_det #(.SYNC_ZEROS(SYNC_ZEROS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .hunt     (hunt),
        .bit_stb  (bit_en),
        .nrz_bit  (nrz_bit),
        .line_bad (is_se0 || is_se1),
        .sop      (sop)
    );

    usb_rx_packer #(.DATA_W(DATA_W), .STUFF_LIMIT(STUFF_LIMIT)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_mode  (raw_mode),
        .bit_stb   (bit_en),
        .nrz_bit   (nrz_bit),
        .raw_bit   (raw_bit),
        .is_se0    (is_se0),
        .is_se1    (is_se1),
        .sop       (sop),
        .hunt      (hunt),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_active (rx_active),
        .rx_error  (rx_error)
    );

    usb_rx_linestate u_ls (
        .clk        (clk),
        .rst_n      (rst_n),
        .suspend    (suspend),
        .line_dp    (line_dp),
        .line_dm    (line_dm),
        .line_state (line_state)
    );

endmodule

// File: rtl/usb_rx_deser_chk.sv
module usb_rx_deser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       line_dp,
    input logic       line_dm,
    input logic       suspend,
    input logic       rx_active,
    input logic       rx_valid,
    input logic       rx_error,
    input logic [1:0] line_state
);

    assert_start_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_active) |-> $past(bit_en));

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_valid_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_active);

    assert_error_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error |-> $fell(rx_active));

    assert_error_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error |=> !rx_error);

    assert_ls_registered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && $past(rst_n)) |-> (line_state == $past({line_dm, line_dp})));

    assert_ls_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |-> (line_state == {line_dm, line_dp}));

endmodule

bind usb_rx_deser usb_rx_deser_chk u_chk (.*);

// File: tb/usb_rx_deser_tb.sv
module usb_rx_deser_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       line_dp = 1'b1;
    logic       line_dm = 1'b0;
    logic       suspend = 1'b0;
    logic [1:0] opmode = 2'b00;
    logic [7:0] rx_data;
    logic       rx_active, rx_valid, rx_error;
    logic [1:0] line_state;

    always #5 clk = ~clk;

    usb_rx_deser u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .line_dp    (line_dp),
        .line_dm    (line_dm),
        .suspend    (suspend),
        .opmode     (opmode),
        .rx_data    (rx_data),
        .rx_active  (rx_active),
        .rx_valid   (rx_valid),
        .rx_error   (rx_error),
        .line_state (line_state)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int         m_state = 0;
    bit         m_prev = 1;
    int         m_zeros = 0;
    int         m_ones = 0;
    bit         m_bits[$];
    logic       e_act = 0, e_val = 0, e_err = 0;
    logic [7:0] e_dat = 0;
    logic [1:0] e_ls = 0;

    always @(posedge clk) begin
        bit se0, se1, nb, b;
        if (!rst_n) begin
            m_state = 0; m_prev = 1; m_zeros = 0; m_ones = 0; m_bits.delete();
            e_act = 0; e_val = 0; e_err = 0; e_ls = 0;
        end else begin
            e_ls  = {line_dm, line_dp};
            e_val = 0;
            e_err = 0;
            if (bit_en) begin
                se0 = !line_dp && !line_dm;
                se1 = line_dp && line_dm;
                nb  = (line_dp == m_prev);
                if (m_state == 0) begin
                    if (se0 || se1) m_zeros = 0;
                    else if (!nb) m_zeros++;
                    else begin
                        if (m_zeros >= 2) begin
                            m_state = 1; e_act = 1; m_ones = 1; m_bits.delete();
                        end
                        m_zeros = 0;
                    end
                end else if (m_state == 1) begin
                    if (se0) begin
                        e_act = 0; e_err = (m_bits.size() != 0); m_state = 0;
                    end else if (se1) begin
                        e_act = 0; e_err = 1; m_state = 2;
                    end else begin
                        b = (opmode == 2'b10) ? line_dp : nb;
                        if (opmode != 2'b10 && m_ones >= 6) begin
                            if (b) begin e_act = 0; e_err = 1; m_state = 2; end
                            else m_ones = 0;
                        end else begin
                            m_bits.push_back(b);
                            m_ones = (opmode == 2'b10) ? 0 : (b ? m_ones + 1 : 0);
                            if (m_bits.size() == 8) begin
                                e_val = 1;
                                foreach (m_bits[i]) e_dat[i] = m_bits[i];
                                m_bits.delete();
                            end
                        end
                    end
                end else if (se0) begin
                    m_state = 0;
                end
                m_prev = (se0 || se1) ? 1'b1 : line_dp;
            end
        end
    end

    // per-clock comparison and packet capture
    logic [7:0] got[$];
    int         errs = 0;

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check("R2 rx_active", rx_active, e_act);
            check("R3 rx_valid", rx_valid, e_val);
            if (e_val) check("R3 rx_data", rx_data, e_dat);
            check("R5 rx_error", rx_error, e_err);
            if (rx_valid) got.push_back(rx_data);
            if (rx_error) errs++;
        end
        if (suspend) check("R10 line_state", line_state, {line_dm, line_dp});
        else         check("R9 line_state", line_state, rst_n ? e_ls : 2'b00);
    end

    // stimulus helpers
    int         gap = 1;
    bit         cur = 1;
    logic [7:0] tx_bytes[$];
    bit         tx_tail[$];

    task automatic put(input bit dp, input bit dm);
        line_dp = dp; line_dm = dm; bit_en = 1'b1;
        @(negedge clk);
        if (gap > 1) begin
            bit_en = 1'b0;
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic put_nrzi(input bit b);
        if (!b) cur = ~cur;
        put(cur, ~cur);
    endtask

    task automatic idle_bits(input int n);
        cur = 1;
        for (int i = 0; i < n; i++) put(1'b1, 1'b0);
        bit_en = 1'b0;
    endtask

    task automatic send_pkt(input bit bypass, input bit se1_end);
        bit wbits[$];
        int ones;
        for (int i = 0; i < 7; i++) put_nrzi(1'b0);
        put_nrzi(1'b1);
        ones = 1;
        foreach (tx_bytes[i]) begin
            for (int k = 0; k < 8; k++) begin
                wbits.push_back(tx_bytes[i][k]);
                if (!bypass) begin
                    if (tx_bytes[i][k]) ones++; else ones = 0;
                    if (ones == 6) begin wbits.push_back(1'b0); ones = 0; end
                end
            end
        end
        foreach (tx_tail[i]) wbits.push_back(tx_tail[i]);
        foreach (wbits[i]) begin
            if (bypass) begin cur = wbits[i]; put(cur, ~cur); end
            else put_nrzi(wbits[i]);
        end
        if (se1_end) begin
            put(1'b1, 1'b1);
            put_nrzi(1'b1);
            put_nrzi(1'b0);
        end
        put(1'b0, 1'b0);
        put(1'b0, 1'b0);
        idle_bits(4);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_pkt(input string tag, input int nbytes, input int nerr);
        check({tag, " byte count"}, got.size(), nbytes);
        for (int i = 0; i < nbytes && i < got.size(); i++)
            check({tag, " byte"}, got[i], tx_bytes[i]);
        check({tag, " error count"}, errs, nerr);
        got.delete();
        errs = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        check("R1 rx_active", rx_active, 1'b0);
        check("R1 rx_valid", rx_valid, 1'b0);
        check("R1 rx_error", rx_error, 1'b0);
        check("R1 line_state", line_state, 2'b00);
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9 / R10: line codes, registered and pass-through, bit_en held low (R12)
        for (int i = 0; i < 12; i++) begin
            suspend = i[2];
            line_dp = i[0];
            line_dm = i[1];
            @(negedge clk);
        end
        suspend = 1'b0;
        line_dp = 1'b1; line_dm = 1'b0;
        gap = 1;
        idle_bits(4);
        check_pkt("R12 idle noise", 0, 0);

        // R6: clean packet, full bytes, no error
        tx_bytes = '{8'hA5, 8'h3C}; tx_tail.delete();
        send_pkt(1'b0, 1'b0);
        check_pkt("R6 clean", 2, 0);

        // R4: heavy stuffing
        tx_bytes = '{8'hFF, 8'hFF, 8'h00, 8'h7E, 8'h80};
        send_pkt(1'b0, 1'b0);
        check_pkt("R4 unstuff", 5, 0);

        // R12: sparse bit strobes
        gap = 3;
        tx_bytes = '{8'hC1, 8'h5E};
        send_pkt(1'b0, 1'b0);
        check_pkt("R12 sparse", 2, 0);
        gap = 1;

        // R6: partial byte at end of packet
        tx_bytes = '{8'h12, 8'h34}; tx_tail = '{1, 0, 1};
        send_pkt(1'b0, 1'b0);
        check_pkt("R6 truncated", 2, 1);

        // R5: violation in the middle of a byte, trailing bits ignored
        tx_bytes = '{8'h0F}; tx_tail = '{1, 1, 1, 1, 1, 1, 1, 0, 0};
        send_pkt(1'b0, 1'b0);
        check_pkt("R5 violation", 1, 1);

        // R11: violation on the byte-completing bit
        tx_bytes = '{8'h5A}; tx_tail = '{0, 1, 1, 1, 1, 1, 1, 1, 1, 0};
        send_pkt(1'b0, 1'b0);
        check_pkt("R11 collision", 1, 1);

        // R7: single-ended one inside a packet
        tx_bytes = '{8'h33}; tx_tail.delete();
        send_pkt(1'b0, 1'b1);
        check_pkt("R7 se1", 1, 1);

        // R8: raw payload mode
        opmode = 2'b10; gap = 2;
        tx_bytes = '{8'hFF, 8'hFF, 8'hC3};
        send_pkt(1'b1, 1'b0);
        check_pkt("R8 raw", 3, 0);
        opmode = 2'b00; gap = 1;

        // R3: normal decoding again after raw mode
        tx_bytes = '{8'h00, 8'h81};
        send_pkt(1'b0, 1'b0);
        check_pkt("R3 recovery", 2, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule